// File: doc/BRIEF.md
# Bus-Cleared Watchdog Timer

This block supervises software progress. Software proves it is alive by writing to one fixed register address on a simple write port. The data value does not matter, and the register cannot be read back. If no such write arrives in time, the timer expires and drives a watchdog reset output high for a fixed number of clock cycles. It also sets a sticky cause flag, which software can inspect after restart and clear through a dedicated input.

The timeout comes from a free-running clock prescaler followed by a small tick counter. Only the tick counter is cleared by the write; the prescaler keeps its phase. The expiry therefore lands anywhere inside a window one prescaler period wide, not at one exact cycle count. With the default parameters and a 6 MHz clock, the window runs from 10.5 ms to 14 ms and the reset pulse lasts 3 ms. While the pulse is high, the tick counter is held at zero, so a new timeout period starts only when the pulse ends.

The asynchronous active-low reset input passes through a two-stage synchronizer before it reaches the internal logic. The internal logic therefore leaves reset on the second clock edge after the input rises.

Top module: `wdt_bus_watchdog`

## Requirements
- R1: A write strobe with `wr_addr_i` equal to `KICK_ADDR` (default 0x26) clears the tick counter for any value on `wr_data_i`. Kicks spaced no more than `(TICKS-1)*PRESCALE` cycles apart keep `wdog_rst_o` low indefinitely.
- R2: With no further kick, `wdog_rst_o` rises between `(TICKS-1)*PRESCALE+1` and `TICKS*PRESCALE` clock edges after the kicking edge, counted inclusively. Every value in that window occurs for some phase of the prescaler.
- R3: `wdog_rst_o` stays high for exactly `PULSE_LEN` consecutive cycles per expiry.
- R4: While `wdog_rst_o` is high, the tick counter is held at zero, and kicks during the pulse do not change its length. Without kicks, the next rise comes inside the R2 window, measured from the edge where the pulse falls.
- R5: `wdog_flag_o` rises on the same edge as `wdog_rst_o` and stays high until it is cleared.
- R6: `flag_clr_i` high at an edge clears `wdog_flag_o`. If an expiry and a clear happen on the same edge, the flag is set.
- R7: Writes to any address other than `KICK_ADDR` have no effect on the timeout.
- R8: While `rst_ni` is low, both outputs are low. After `rst_ni` rises, the first expiry comes exactly `TICKS*PRESCALE+2` edges later. The extra two edges come from the reset synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| wr_en_i | input | 1 | Write strobe of the register port |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data (value ignored) |
| flag_clr_i | input | 1 | Clears the watchdog cause flag |
| wdog_rst_o | output | 1 | Watchdog reset pulse |
| wdog_flag_o | output | 1 | Sticky flag recording a watchdog expiry |

## Verification
The bench builds the block with a prescaler of 4, four ticks and a 5-cycle pulse. A full timeout then takes at most 16 cycles, and the 13-to-16 cycle window is small enough to reach every one of its values. It sweeps the kick over every prescaler phase and checks that both ends of the window occur. It cycles through all 255 foreign addresses and all 256 data values, one timeout at a time. Pulse length, flag priority and the exact first expiry after reset are each checked to the cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [0:0] {
    PULSE_IDLE   = 1'b0,
    PULSE_ACTIVE = 1'b1
  } pulse_state_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 21000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q == LAST);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // Phase wraps to zero after each tick: the period is exactly DIV cycles
  assert_prescale_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  input  logic hold_i,
  output logic roll_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    roll_o = tick_i && !clear_i && !hold_i && (cnt_q == LAST);
    cnt_en = clear_i || hold_i || tick_i;
    if (clear_i || hold_i || roll_o) cnt_d = '0;
    else                             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_kick_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));

  assert_hold_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen
  import wdt_pkg::*;
#(
  parameter int LEN = 18000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o
);
  localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  pulse_state_e  state_q, state_d;
  logic [CW-1:0] len_q, len_d;

  always_comb begin
    state_d = state_q;
    len_d   = len_q;
    unique case (state_q)
      PULSE_IDLE: begin
        len_d = '0;
        if (fire_i) state_d = PULSE_ACTIVE;
      end
      PULSE_ACTIVE: begin
        if (len_q == LAST) begin
          state_d = PULSE_IDLE;
          len_d   = '0;
        end else begin
          len_d = len_q + 1'b1;
        end
      end
      default: state_d = PULSE_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PULSE_IDLE;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
    end
  end

  assign active_o = (state_q == PULSE_ACTIVE);

  assert_pulse_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(fire_i));

  assert_pulse_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && len_q == LAST) |=> !active_o);
endmodule

// File: rtl/wdt_bus_watchdog.sv
module wdt_bus_watchdog #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] KICK_ADDR = 8'h26,
  parameter int                PRESCALE  = 21000,
  parameter int                TICKS     = 4,
  parameter int                PULSE_LEN = 18000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              flag_clr_i,
  output logic              wdog_rst_o,
  output logic              wdog_flag_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       kick;
  logic       tick;
  logic       roll;
  logic       pulse_active;
  logic       flag_q, flag_d, flag_en;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign kick = wr_en_i && (wr_addr_i == KICK_ADDR);

  wdt_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .tick_o (tick)
  );

  wdt_tick_counter #(.LIMIT(TICKS)) u_ticks (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .tick_i  (tick),
    .clear_i (kick),
    .hold_i  (pulse_active),
    .roll_o  (roll)
  );

  wdt_pulse_gen #(.LEN(PULSE_LEN)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .fire_i   (roll),
    .active_o (pulse_active)
  );

  // Cause flag: set wins over clear
  always_comb begin
    flag_en = roll || flag_clr_i;
    flag_d  = roll;
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int)   flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign wdog_rst_o  = pulse_active;
  assign wdog_flag_o = flag_q;

  assert_flag_with_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    $rose(wdog_rst_o) |-> wdog_flag_o);

  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (wdog_flag_o && !flag_clr_i) |=> wdog_flag_o);

  assert_kick_data_known_R1: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    wr_en_i |-> !$isunknown(wr_data_i));

  assert_reset_quiet_R8: assert property (@(posedge clk_i)
    !rst_n_int |-> (!wdog_rst_o && !wdog_flag_o));
endmodule

// File: tb/sim_wdt_bus_watchdog.sv
module sim_wdt_bus_watchdog;
  localparam int P  = 4;
  localparam int T  = 4;
  localparam int PL = 5;
  localparam int LO = (T - 1) * P + 1;
  localparam int HI = T * P;
  localparam logic [7:0] KA = 8'h26;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       flag_clr;
  logic       wdog_rst;
  logic       wdog_flag;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  wdt_bus_watchdog #(
    .ADDR_W(8), .DATA_W(8), .KICK_ADDR(KA),
    .PRESCALE(P), .TICKS(T), .PULSE_LEN(PL)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .flag_clr_i(flag_clr),
    .wdog_rst_o(wdog_rst), .wdog_flag_o(wdog_flag)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One-cycle kick; returns at the negedge after the kicking edge
  task automatic kick(input logic [7:0] d);
    wr_en = 1'b1; wr_addr = KA; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  // Edges until wdog_rst is seen high, counting the first edge as 1
  task automatic wait_rise(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!wdog_rst && n < 500);
  endtask

  task automatic wait_fall();
    int g = 0;
    while (wdog_rst && g < 500) begin
      step();
      g++;
    end
  endtask

  initial begin
    int d, n, mn, mx, addr;
    bit alive_ok;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; flag_clr = 1'b0;
    repeat (3) step();
    // R8: quiet during reset
    check(wdog_rst == 1'b0, "R8 reset rst", int'(wdog_rst), 0);
    check(wdog_flag == 1'b0, "R8 reset flag", int'(wdog_flag), 0);
    rst_n = 1'b1;
    wait_rise(d);
    check(d == HI + 2, "R8 first expiry", d, HI + 2);
    check(wdog_flag == 1'b1, "R5 flag at rise", int'(wdog_flag), 1);

    // R3/R4: pulse length, with kicks during the pulse
    n = 1;
    forever begin
      wr_en = 1'b1; wr_addr = KA; wr_data = 8'hA5;
      step();
      if (wdog_rst) n++;
      else break;
    end
    wr_en = 1'b0;
    check(n == PL, "R3 pulse length", n, PL);
    check(wdog_flag == 1'b1, "R5 flag sticky", int'(wdog_flag), 1);
    // R4: counter restarts from pulse end
    wait_rise(d);
    check(d >= LO && d <= HI, "R4 timeout after pulse", d, HI);
    wait_fall();

    // R6: clear
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
    check(wdog_flag == 1'b0, "R6 flag clear", int'(wdog_flag), 0);

    // R2: sweep kick phase
    mn = 1000; mx = 0;
    for (int off = 0; off < 2 * P; off++) begin
      repeat (off) step();
      kick(8'(off));
      wait_rise(d);
      check(d >= LO && d <= HI, "R2 window", d, LO);
      if (d < mn) mn = d;
      if (d > mx) mx = d;
      wait_fall();
    end
    check(mn == LO, "R2 window low end", mn, LO);
    check(mx == HI, "R2 window high end", mx, HI);

    // R7: foreign addresses do not kick
    addr = 0;
    while (addr < 256) begin
      kick(8'h00);
      d = 0;
      do begin
        if (addr == int'(KA)) addr++;
        wr_en = (addr < 256); wr_addr = 8'(addr); wr_data = 8'hFF;
        addr++;
        step();
        d++;
      end while (!wdog_rst && d < 500);
      wr_en = 1'b0;
      check(d >= LO && d <= HI, "R7 foreign writes", d, HI);
      wait_fall();
    end

    // R1: kicks with every data value keep the reset low
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
    for (int v = 0; v < 256; v++) begin
      alive_ok = 1'b1;
      kick(8'(v));
      if (wdog_rst) alive_ok = 1'b0;
      repeat (LO - 2) begin
        step();
        if (wdog_rst) alive_ok = 1'b0;
      end
      check(alive_ok, "R1 kick keeps alive", int'(wdog_rst), 0);
    end
    check(wdog_flag == 1'b0, "R1 no flag while kicked", int'(wdog_flag), 0);

    // R6: set wins over simultaneous clear
    flag_clr = 1'b1;
    wait_rise(d);
    check(wdog_flag == 1'b1, "R6 set priority", int'(wdog_flag), 1);
    step();
    check(wdog_flag == 1'b0, "R6 clear after set", int'(wdog_flag), 0);
    flag_clr = 1'b0;
    wait_fall();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule